// File: doc/BRIEF.md
# Enable-Gated Digit Sequencer

This block is a small clocked controller that walks through a fixed loop of four decimal digits, 4, 6, 9 and 1, and shows the current one as a 4-bit binary value. A two-bit state register holds the position in the loop. The output is decoded from that registered state alone, so the digit depends only on the present state.

A single enable input gates progress. While it is high, the machine moves one position on every rising clock edge. After the last digit it returns to the first. While enable is low, the position and the digit stay where they are.

An asynchronous active-low reset puts the machine at the first digit at once. Its release passes through a short synchronizer, so stepping resumes only a fixed number of edges after reset is released.

Top module: `digit_sequencer`

## Requirements
- R1: While `rst_n` is low, `digit` is 4'b0100 (decimal 4). This holds at once, with no clock edge needed, and whatever level `advance_en` has.
- R2: After `rst_n` rises, the first SYNC_STAGES rising edges (default 2) leave `digit` at 4 even with `advance_en` high. The following edge is the first one that can advance it.
- R3: With `advance_en` high at a rising edge, `digit` takes the next value of the loop 4 → 6 → 9 → 1. The binary codes are 0100, 0110, 1001 and 0001. The state codes are 00, 01, 10 and 11 in that order.
- R4: With `advance_en` low at a rising edge, `digit` keeps its value, however many such edges follow one another.
- R5: Outside reset, `digit` only ever shows one of the four codes 0100, 0110, 1001 or 0001.
- R6: `digit` changes only just after a rising clock edge. Toggling `advance_en` between edges leaves it unchanged until the next edge.
- R7: With `advance_en` high while `digit` is 1, the next edge returns `digit` to 4. The loop repeats indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| advance_en | input | 1 | High: step one digit per edge; low: hold |
| digit | output | DIGIT_W (4) | Current digit, binary coded |

## Verification
The hardest situation to reach is the boundary around reset release. There, enable is already high but the synchronizer still holds the state register. The stimulus raises reset at a falling edge with enable held high, then samples the digit after each of the next three rising edges, which shows exactly when stepping starts. A second hard case is enable changing between edges. The bench toggles it several times inside one clock period and checks that the digit is unchanged until the next edge. A table of enable levels then covers two full wrap-arounds with holds of several cycles placed mid-loop.

// File: rtl/digseq_pkg.sv
package digseq_pkg;

  localparam int DIGIT_W = 4;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_FOUR = 2'b00,
    ST_SIX  = 2'b01,
    ST_NINE = 2'b10,
    ST_ONE  = 2'b11
  } step_e;

  localparam logic [DIGIT_W-1:0] DIG_FOUR = 4'd4;
  localparam logic [DIGIT_W-1:0] DIG_SIX  = 4'd6;
  localparam logic [DIGIT_W-1:0] DIG_NINE = 4'd9;
  localparam logic [DIGIT_W-1:0] DIG_ONE  = 4'd1;

endpackage

// File: rtl/digseq_rst_sync.sv
module digseq_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_STAGES-1:0] chain_q;

  // asserts immediately, releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/digseq_next.sv
module digseq_next
  import digseq_pkg::*;
(
  input  step_e cur_state,
  output step_e succ_state
);

  always_comb begin
    unique case (cur_state)
      ST_FOUR: succ_state = ST_SIX;
      ST_SIX:  succ_state = ST_NINE;
      ST_NINE: succ_state = ST_ONE;
      ST_ONE:  succ_state = ST_FOUR;
      default: succ_state = ST_FOUR;
    endcase
  end

endmodule

// File: rtl/digseq_state_reg.sv
module digseq_state_reg
  import digseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_en,
  input  step_e d_state,
  output step_e q_state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_state <= ST_FOUR;
    end else if (step_en) begin
      q_state <= d_state;
    end
  end

endmodule

// File: rtl/digseq_decode.sv
module digseq_decode
  import digseq_pkg::*;
(
  input  step_e                 state,
  output logic [DIGIT_W-1:0]    value
);

  always_comb begin
    unique case (state)
      ST_FOUR: value = DIG_FOUR;
      ST_SIX:  value = DIG_SIX;
      ST_NINE: value = DIG_NINE;
      ST_ONE:  value = DIG_ONE;
      default: value = DIG_FOUR;
    endcase
  end

endmodule

// File: rtl/digit_sequencer.sv
module digit_sequencer
  import digseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance_en,
  output logic [DIGIT_W-1:0] digit
);

  logic  rst_run_n;
  step_e state_q;
  step_e state_d;

  digseq_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_run_n)
  );

  digseq_next u_next (
    .cur_state  (state_q),
    .succ_state (state_d)
  );

  digseq_state_reg u_state (
    .clk     (clk),
    .rst_n   (rst_run_n),
    .step_en (advance_en),
    .d_state (state_d),
    .q_state (state_q)
  );

  digseq_decode u_dec (
    .state (state_q),
    .value (digit)
  );

endmodule

// File: rtl/digseq_checker.sv
module digseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run_n,
  input logic       en,
  input logic [3:0] digit
);

  function automatic logic [3:0] follow(input logic [3:0] d);
    case (d)
      4'd4:    follow = 4'd6;
      4'd6:    follow = 4'd9;
      4'd9:    follow = 4'd1;
      default: follow = 4'd4;
    endcase
  endfunction

  // R1: reset shows digit 4
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_four_r1: assert (digit == 4'd4)
        else $error("p_reset_four_r1");
    end
  end

  // R3: step to successor while enabled
  p_step_next_r3: assert property (@(posedge clk) disable iff (!run_n)
    en |=> digit == follow($past(digit)));

  // R4: hold while disabled
  p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(digit));

  // R5: only legal digits
  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (digit == 4'd4) || (digit == 4'd6) || (digit == 4'd9) || (digit == 4'd1));

  // R7: wrap from 1 back to 4
  p_wrap_back_r7: assert property (@(posedge clk) disable iff (!run_n)
    (en && digit == 4'd1) |=> digit == 4'd4);

  // R2: held at 4 while synchronized reset still active
  p_sync_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_n |=> digit == 4'd4);

endmodule

bind digit_sequencer digseq_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run_n (rst_run_n),
  .en    (advance_en),
  .digit (digit)
);

// File: tb/tb_digit_sequencer.sv
`timescale 1ns/1ps
module tb_digit_sequencer;

  localparam real TCK = 8.0;
  localparam int  NVEC = 22;

  // {advance_en, expected digit after the edge}
  localparam logic [4:0] VEC [NVEC] = '{
    {1'b1, 4'd6}, {1'b1, 4'd9}, {1'b1, 4'd1}, {1'b1, 4'd4},
    {1'b0, 4'd4}, {1'b0, 4'd4}, {1'b0, 4'd4}, {1'b1, 4'd6},
    {1'b0, 4'd6}, {1'b1, 4'd9}, {1'b1, 4'd1}, {1'b0, 4'd1},
    {1'b0, 4'd1}, {1'b1, 4'd4}, {1'b1, 4'd6}, {1'b1, 4'd9},
    {1'b1, 4'd1}, {1'b1, 4'd4}, {1'b1, 4'd6}, {1'b0, 4'd6},
    {1'b1, 4'd9}, {1'b1, 4'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       advance_en;
  logic [3:0] digit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(TCK/2) clk = ~clk;

  digit_sequencer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance_en (advance_en),
    .digit      (digit)
  );

  task automatic check(input string req, input logic [3:0] exp);
    total++;
    if (digit !== exp) begin
      bad++;
      $display("FAIL %s: digit=%0d expected=%0d at %0t", req, digit, exp, $time);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    advance_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 4'd4);

    // R2: release with enable high
    rst_n = 1'b1;
    @(negedge clk); check("R2", 4'd4);
    @(negedge clk); check("R2", 4'd4);
    @(negedge clk); check("R2", 4'd6);
    @(negedge clk); check("R3", 4'd9);

    // R1: asynchronous reset mid-cycle
    #1 rst_n = 1'b0;
    #1 check("R1", 4'd4);
    @(negedge clk);
    advance_en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R4", 4'd4);

    // table walk: R3, R4, R5, R7
    for (int i = 0; i < NVEC; i++) begin
      advance_en = VEC[i][4];
      @(posedge clk);
      @(negedge clk);
      check(VEC[i][3:0] == 4'd4 && i > 0 && VEC[i][4] ? "R7" :
            (VEC[i][4] ? "R3" : "R4"), VEC[i][3:0]);
      if (!(digit == 4'd4 || digit == 4'd6 || digit == 4'd9 || digit == 4'd1))
        check("R5", 4'd4);
    end

    // R6: toggles between edges have no effect
    advance_en = 1'b0;
    #0.5 advance_en = 1'b1;
    #0.5 check("R6", 4'd1);
    advance_en = 1'b0;
    #0.5 check("R6", 4'd1);
    advance_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7", 4'd4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TCK * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: digit=%0d expected=finish", digit);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule